// File: doc/BRIEF.md
# Load/Store Address Watch Unit

This unit monitors the effective addresses of data accesses and records debug hits when an access falls on a programmed watch address. It holds two 32-bit watch values, A and B. In the normal mode each one works as its own exact comparator. A 2-bit granule field per watch value lets that comparator ignore 0, 1, 2 or 5 low address bits. This makes a watch react to any byte of a halfword, a word or an eight-word line.

The two watch values can also be joined into one half-open address range. The range either includes the addresses from A up to, but not including, B, or it includes everything outside that span. While range mode is active, exact matching is switched off. An access that needs several effective addresses, such as an unaligned or multi-word transfer, arrives as several single-cycle accesses, and the unit judges each one separately.

Hits are stored in four sticky status bits. Software clears them by writing ones to a clear mask. A single-cycle event output pulses whenever a status bit goes from clear to set.

Top module: `dac_watch_unit`

## Requirements
- R1: After reset, `hit_status` is 4'b0000 and `debug_event` is 0.
- R2: In exact mode, watch A matches when the address equals `watch_a` after both are masked by `gran_a`: 2'b00 compares all 32 bits, 2'b01 ignores bit 0, 2'b10 ignores bits 1:0, and 2'b11 ignores bits 4:0. The same rule holds for watch B with `gran_b`.
- R3: Status bit positions are fixed as follows: bit 0 is read hit A, bit 1 is read hit B, bit 2 is write hit A, and bit 3 is write hit B. An exact hit on watch n sets the read bit of n only if `acc_write`=0 and `rd_en[n]`=1. It sets the write bit of n only if `acc_write`=1 and `wr_en[n]`=1. Index 0 of `rd_en` and `wr_en` is watch A, and index 1 is watch B.
- R4: Range mode is active when `range_mode`=1 and at least one bit of `rd_en` or `wr_en` is set. While range mode is active, no exact comparison sets any status bit.
- R5: An inclusive range (`range_invert`=0) matches when `watch_a` <= address < `watch_b`.
- R6: An inverted range (`range_invert`=1) matches when address < `watch_a` or address >= `watch_b`.
- R7: A range match sets the status bit of every enabled comparator in the access's direction. For a read, these are the bits of `rd_en` that are set. For a write, these are the bits of `wr_en` that are set.
- R8: Status bits are set on the clock edge after a qualifying access and stay set until a 1 is written to the matching bit of `clr_mask`. If a set and a clear of the same bit fall in the same cycle, the bit stays set.
- R9: `debug_event` is 1 for exactly the cycle in which at least one status bit has just changed from 0 to 1. A hit on a bit that is already set does not raise it.
- R10: When every bit of `rd_en` and `wr_en` is 0, no access sets a status bit or raises `debug_event`.
- R11: Range comparisons are unsigned 32-bit magnitude comparisons, and the granule fields have no effect in range mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access address is present this cycle |
| acc_addr | input | 32 | Effective address of the access |
| acc_write | input | 1 | 1 = store, 0 = load |
| watch_a | input | 32 | Watch value A (range lower bound) |
| watch_b | input | 32 | Watch value B (range upper bound) |
| gran_a | input | 2 | Granule field for watch A |
| gran_b | input | 2 | Granule field for watch B |
| rd_en | input | 2 | Read enables, index 0 = A, index 1 = B |
| wr_en | input | 2 | Write enables, index 0 = A, index 1 = B |
| range_mode | input | 1 | Join A and B into one range |
| range_invert | input | 1 | Select the outside of the range |
| clr_mask | input | 4 | Write-one-to-clear pulse for the status bits |
| hit_status | output | 4 | Sticky hit bits {wr B, wr A, rd B, rd A} |
| debug_event | output | 1 | One-cycle pulse when a status bit is newly set |

## Verification
A status set and a software clear of the same bit can fall in the same cycle. To provoke this, the bench sets a bit, then drives a matching access and a clear pulse for that bit at the same clock edge. The result passes if the bit stays set and `debug_event` stays low, because the bit was already set. A second collision, between an exact match and a range match, is provoked by placing an address exactly on `watch_b` while range mode is active. The result passes if nothing is recorded, because the upper bound lies outside the inclusive range.

// File: rtl/dac_pkg.sv
package dac_pkg;
    localparam int AW    = 32;
    localparam int NCMP  = 2;
    localparam int NSTAT = 2 * NCMP;

    typedef struct packed {
        logic [NSTAT-1:0] status;
        logic             evt;
    } dac_state_t;

    function automatic logic [AW-1:0] gran_mask(input logic [1:0] g);
        logic [AW-1:0] m;
        m = '1;
        case (g)
            2'b01:   m[0]   = 1'b0;
            2'b10:   m[1:0] = 2'b00;
            2'b11:   m[4:0] = 5'b00000;
            default: m      = '1;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/dac_exact_cmp.sv
module dac_exact_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] addr,
    input  logic [W-1:0] watch,
    input  logic [W-1:0] mask,
    output logic         hit
);
    always_comb begin
        hit = (((addr ^ watch) & mask) == '0);
    end
endmodule

// File: rtl/dac_range_cmp.sv
module dac_range_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] addr,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic         invert,
    output logic         hit
);
    logic below_lo;
    logic below_hi;

    always_comb begin
        below_lo = (addr < lo);
        below_hi = (addr < hi);
        if (invert) begin
            hit = below_lo || !below_hi;
        end else begin
            hit = !below_lo && below_hi;
        end
    end
endmodule

// File: rtl/dac_watch_unit.sv
module dac_watch_unit
    import dac_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic [31:0]   acc_addr,
    input  logic          acc_write,
    input  logic [31:0]   watch_a,
    input  logic [31:0]   watch_b,
    input  logic [1:0]    gran_a,
    input  logic [1:0]    gran_b,
    input  logic [1:0]    rd_en,
    input  logic [1:0]    wr_en,
    input  logic          range_mode,
    input  logic          range_invert,
    input  logic [3:0]    clr_mask,
    output logic [3:0]    hit_status,
    output logic          debug_event
);
    logic [AW-1:0]   watch_v [NCMP];
    logic [1:0]      gran_v  [NCMP];
    logic [NCMP-1:0] exact_hit;
    logic            range_hit;
    logic            range_active;

    dac_state_t state_d, state_q;

    assign watch_v[0] = watch_a;
    assign watch_v[1] = watch_b;
    assign gran_v[0]  = gran_a;
    assign gran_v[1]  = gran_b;

    for (genvar i = 0; i < NCMP; i++) begin : g_exact
        dac_exact_cmp #(.W(AW)) cmp_i (
            .addr  (acc_addr),
            .watch (watch_v[i]),
            .mask  (gran_mask(gran_v[i])),
            .hit   (exact_hit[i])
        );
    end

    dac_range_cmp #(.W(AW)) rng_i (
        .addr   (acc_addr),
        .lo     (watch_a),
        .hi     (watch_b),
        .invert (range_invert),
        .hit    (range_hit)
    );

    always_comb begin
        logic [NCMP-1:0]  match;
        logic [NSTAT-1:0] set;
        range_active = range_mode && ((rd_en | wr_en) != '0);
        match = range_active ? {NCMP{range_hit}} : exact_hit;
        set = '0;
        if (acc_valid) begin
            if (acc_write) begin
                set[NSTAT-1:NCMP] = match & wr_en;
            end else begin
                set[NCMP-1:0] = match & rd_en;
            end
        end
        state_d.status = (state_q.status & ~clr_mask) | set;
        state_d.evt    = ((set & ~state_q.status) != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign hit_status  = state_q.status;
    assign debug_event = state_q.evt;
endmodule

// File: rtl/dac_watch_unit_chk.sv
module dac_watch_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic [1:0] rd_en,
    input logic [1:0] wr_en,
    input logic [3:0] clr_mask,
    input logic [3:0] hit_status,
    input logic       debug_event
);
    assert_set_needs_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> ((hit_status & ~$past(hit_status)) == 4'b0000));

    assert_sticky_without_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask == 4'b0000) |=> ((hit_status & $past(hit_status)) == $past(hit_status)));

    assert_event_means_new_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(debug_event) |-> ((hit_status & ~$past(hit_status)) != 4'b0000));

    assert_silent_when_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en == 2'b00 && wr_en == 2'b00) |=> !debug_event);
endmodule

bind dac_watch_unit dac_watch_unit_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .clr_mask    (clr_mask),
    .hit_status  (hit_status),
    .debug_event (debug_event)
);

// File: tb/dac_watch_unit_tb_top.sv
module dac_watch_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic [31:0] watch_a = '0;
    logic [31:0] watch_b = '0;
    logic [1:0]  gran_a = '0;
    logic [1:0]  gran_b = '0;
    logic [1:0]  rd_en = '0;
    logic [1:0]  wr_en = '0;
    logic        range_mode = 1'b0;
    logic        range_invert = 1'b0;
    logic [3:0]  clr_mask = '0;
    logic [3:0]  hit_status;
    logic        debug_event;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dac_watch_unit dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .watch_a(watch_a), .watch_b(watch_b),
        .gran_a(gran_a), .gran_b(gran_b), .rd_en(rd_en), .wr_en(wr_en),
        .range_mode(range_mode), .range_invert(range_invert),
        .clr_mask(clr_mask), .hit_status(hit_status), .debug_event(debug_event)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one-cycle access driven at negedge, results sampled at the following negedge
    task automatic access(input logic [31:0] a, input logic w);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = w;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_mask = 4'hF;
        @(negedge clk);
        clr_mask = 4'h0;
    endtask

    task automatic hit_then_clear(input string req, input logic [31:0] a,
                                  input logic w, input logic [3:0] exp);
        access(a, w);
        check(req, {28'b0, hit_status}, {28'b0, exp});
        clear_all();
        check(req, {28'b0, hit_status}, 32'h0);
    endtask

    task automatic t_reset();
        check("R1 status", {28'b0, hit_status}, 32'h0);
        check("R1 event", {31'b0, debug_event}, 32'h0);
    endtask

    task automatic t_exact_gran();
        watch_a = 32'h1000_0103; rd_en = 2'b01; wr_en = 2'b00; range_mode = 1'b0;
        gran_a = 2'b00;
        hit_then_clear("R2 byte equal", 32'h1000_0103, 1'b0, 4'b0001);
        hit_then_clear("R2 byte neighbour", 32'h1000_0102, 1'b0, 4'b0000);
        gran_a = 2'b01;
        hit_then_clear("R2 halfword", 32'h1000_0102, 1'b0, 4'b0001);
        hit_then_clear("R2 halfword out", 32'h1000_0101, 1'b0, 4'b0000);
        gran_a = 2'b10;
        hit_then_clear("R2 word", 32'h1000_0100, 1'b0, 4'b0001);
        hit_then_clear("R2 word out", 32'h1000_0104, 1'b0, 4'b0000);
        gran_a = 2'b11;
        hit_then_clear("R2 line", 32'h1000_011F, 1'b0, 4'b0001);
        hit_then_clear("R2 line out", 32'h1000_0120, 1'b0, 4'b0000);
        gran_a = 2'b00;
    endtask

    task automatic t_direction();
        watch_a = 32'h0000_4000; watch_b = 32'h0000_8000;
        rd_en = 2'b01; wr_en = 2'b00;
        hit_then_clear("R3 write ignored by read enable", 32'h0000_4000, 1'b1, 4'b0000);
        rd_en = 2'b00; wr_en = 2'b01;
        hit_then_clear("R3 write A", 32'h0000_4000, 1'b1, 4'b0100);
        hit_then_clear("R3 read ignored by write enable", 32'h0000_4000, 1'b0, 4'b0000);
        rd_en = 2'b10; wr_en = 2'b00;
        hit_then_clear("R3 read B", 32'h0000_8000, 1'b0, 4'b0010);
        rd_en = 2'b00; wr_en = 2'b10;
        hit_then_clear("R3 write B", 32'h0000_8000, 1'b1, 4'b1000);
    endtask

    task automatic t_range_incl();
        watch_a = 32'h100; watch_b = 32'h200; range_mode = 1'b1; range_invert = 1'b0;
        rd_en = 2'b11; wr_en = 2'b00;
        hit_then_clear("R5 lower bound", 32'h100, 1'b0, 4'b0011);
        hit_then_clear("R5 top inside", 32'h1FF, 1'b0, 4'b0011);
        hit_then_clear("R4 upper bound, exact off", 32'h200, 1'b0, 4'b0000);
        hit_then_clear("R5 below", 32'h0FF, 1'b0, 4'b0000);
        rd_en = 2'b01; wr_en = 2'b11;
        hit_then_clear("R7 write all enabled", 32'h150, 1'b1, 4'b1100);
        hit_then_clear("R7 read enabled only", 32'h150, 1'b0, 4'b0001);
        watch_a = 32'h110; gran_a = 2'b11; rd_en = 2'b01; wr_en = 2'b00;
        hit_then_clear("R11 no granule in range", 32'h105, 1'b0, 4'b0000);
        gran_a = 2'b00;
    endtask

    task automatic t_range_excl();
        watch_a = 32'h100; watch_b = 32'h200; range_mode = 1'b1; range_invert = 1'b1;
        rd_en = 2'b01; wr_en = 2'b00;
        hit_then_clear("R6 below lower", 32'h0FF, 1'b0, 4'b0001);
        hit_then_clear("R6 upper bound", 32'h200, 1'b0, 4'b0001);
        hit_then_clear("R6 lower inside", 32'h100, 1'b0, 4'b0000);
        hit_then_clear("R6 top inside", 32'h1FF, 1'b0, 4'b0000);
        hit_then_clear("R11 unsigned top", 32'hFFFF_FFFF, 1'b0, 4'b0001);
        range_invert = 1'b0;
        hit_then_clear("R11 unsigned not negative", 32'h8000_0000, 1'b0, 4'b0000);
        range_mode = 1'b0;
    endtask

    task automatic t_sticky_event();
        watch_a = 32'h2000; rd_en = 2'b01; wr_en = 2'b00; range_mode = 1'b0;
        access(32'h2000, 1'b0);
        check("R9 event on new bit", {31'b0, debug_event}, 32'h1);
        @(negedge clk);
        check("R9 event one cycle", {31'b0, debug_event}, 32'h0);
        repeat (3) @(negedge clk);
        check("R8 sticky", {28'b0, hit_status}, 32'h1);
        access(32'h2000, 1'b0);
        check("R9 no event on set bit", {31'b0, debug_event}, 32'h0);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 32'h2000; acc_write = 1'b0; clr_mask = 4'b0001;
        @(negedge clk);
        acc_valid = 1'b0; clr_mask = 4'b0000;
        check("R8 set wins over clear", {28'b0, hit_status}, 32'h1);
        check("R9 no event on collision", {31'b0, debug_event}, 32'h0);
        @(negedge clk);
        clr_mask = 4'b0001;
        @(negedge clk);
        clr_mask = 4'b0000;
        check("R8 clear", {28'b0, hit_status}, 32'h0);
    endtask

    task automatic t_disabled();
        watch_a = 32'h3000; watch_b = 32'h3000; rd_en = 2'b00; wr_en = 2'b00;
        range_mode = 1'b0;
        access(32'h3000, 1'b0);
        check("R10 read status", {28'b0, hit_status}, 32'h0);
        check("R10 read event", {31'b0, debug_event}, 32'h0);
        range_mode = 1'b1; range_invert = 1'b1;
        access(32'h3000, 1'b1);
        check("R10 write status", {28'b0, hit_status}, 32'h0);
        range_mode = 1'b0; range_invert = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exact_gran();
        t_direction();
        t_range_incl();
        t_range_excl();
        t_sticky_event();
        t_disabled();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule